// File: doc/BRIEF.md
# Handshake Line Glitch Filter

This block cleans the two asynchronous handshake inputs of a parallel peripheral bus, the request line and the acknowledge line, before the protocol sequencer sees them. Reflections and spikes on these lines can otherwise start a false handshake, add a stray data byte, or clock one transfer twice. The data lines are left unfiltered; only the two handshake lines are treated.

Each line first passes through a two-flop synchroniser. A width qualifier then lets the filtered output take a new level only after the synchronised input has shown that level for a minimum number of consecutive clocks. Any reversal before that restarts the count. The minimum width is chosen by a 2-bit field in an 8-bit control register, which is written and read over a small register port. The field selects bypass, a 12 ns default, a 24 ns step or a 35 ns maximum. The clock counts for these windows are derived at elaboration from the clock-period parameter, for clocks from 10 to 40 MHz or faster. Each filtered line also gives a one-cycle assert strobe and a one-cycle deassert strobe.

Top module: `hs_deglitch_top`

## Requirements
- R1: After reset, both clean outputs and all four strobes are 0, and the control register holds 0x40, so the window code is 01.
- R2: The control register sits at address 0x0D. It is written when cfg_we is high at a clock edge. cfg_rdata is registered: it shows the register one cycle after cfg_addr selects 0x0D, and 0x00 for any other address. Writes to other addresses change nothing.
- R3: All eight register bits read back as written. Bits 5:0 have no effect on filtering.
- R4: Bits 7:6 select the minimum stable count N in clocks: 00 gives 0 (bypass), 01 gives ceil(12000/CLK_PS), 10 gives ceil(24000/CLK_PS) and 11 gives ceil(35000/CLK_PS). With CLK_PS = 4000 these are 0, 3, 6 and 9.
- R5: A level change on an input that is held reaches the clean output 2 + max(N,1) clock edges after the edge that first samples it.
- R6: A pulse that the synchroniser samples on fewer than N consecutive edges changes neither the clean output nor any strobe. A reversal restarts the count, so separate short pulses never add up.
- R7: The rise strobe is high for exactly the one cycle in which the clean output goes 0 to 1. The fall strobe does the same for 1 to 0. The two strobes are never high together.
- R8: The request and acknowledge lines are filtered independently. Activity on one never moves the other's outputs.
- R9: With code 00, a pulse sampled on a single edge passes to the clean output and produces both strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Registered read data |
| req_async | input | 1 | Raw request line |
| ack_async | input | 1 | Raw acknowledge line |
| req_clean | output | 1 | Filtered request level |
| ack_clean | output | 1 | Filtered acknowledge level |
| req_rise | output | 1 | One-cycle strobe when req_clean asserts |
| req_fall | output | 1 | One-cycle strobe when req_clean deasserts |
| ack_rise | output | 1 | One-cycle strobe when ack_clean asserts |
| ack_fall | output | 1 | One-cycle strobe when ack_clean deasserts |

## Verification
The hardest case to reach is a run of pulses that are each one clock shorter than the window, with a single low sample between them. A filter that failed to clear its count on a reversal would add these up and pass them. The stimulus drives the raw line on the falling clock edge, so every pulse covers an exact number of sampling edges. It then repeats the exact-width and one-short cases for each window code after rewriting the register, so each boundary is hit at both N-1 and N.

// File: rtl/hs_deglitch_pkg.sv
package hs_deglitch_pkg;
  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned LINE_REQ  = 0;
  localparam int unsigned LINE_ACK  = 1;

  typedef enum logic [1:0] {
    WIN_BYPASS = 2'b00,
    WIN_SHORT  = 2'b01,
    WIN_MID    = 2'b10,
    WIN_LONG   = 2'b11
  } win_code_e;

  function automatic int unsigned win_cycles(input int unsigned win_ps,
                                             input int unsigned clk_ps);
    return (win_ps + clk_ps - 1) / clk_ps;
  endfunction
endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic d_sync
);
  logic meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      d_sync <= 1'b0;
    end else begin
      meta_q <= d_async;
      d_sync <= meta_q;
    end
  end
endmodule

// File: rtl/hs_width_qual.sv
module hs_width_qual #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [CNT_W-1:0] limit,
  output logic             q,
  output logic             rise,
  output logic             fall
);
  logic [CNT_W-1:0] run_cnt;
  logic             take;

  // Accept the new level on the limit-th consecutive differing sample.
  assign take = (limit == '0) || (run_cnt >= limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      q       <= 1'b0;
      rise    <= 1'b0;
      fall    <= 1'b0;
      run_cnt <= '0;
    end else begin
      rise <= 1'b0;
      fall <= 1'b0;
      if (din == q) begin
        run_cnt <= '0;
      end else if (take) begin
        q       <= din;
        rise    <= din;
        fall    <= ~din;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hs_cfg_reg.sv
module hs_cfg_reg #(
  parameter int unsigned ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'hD,
  parameter logic [7:0]  RESET_VAL = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [1:0]        win_code
);
  logic [7:0] ctrl_q;
  logic       hit;

  assign hit      = (addr == CTRL_ADDR);
  assign win_code = ctrl_q[7:6];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= RESET_VAL;
      rdata  <= 8'h00;
    end else begin
      if (we && hit) ctrl_q <= wdata;
      rdata <= hit ? ctrl_q : 8'h00;
    end
  end
endmodule

// File: rtl/hs_deglitch_top.sv
module hs_deglitch_top #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CLK_PS   = 25000,
  parameter int unsigned WIN1_PS  = 12000,
  parameter int unsigned WIN2_PS  = 24000,
  parameter int unsigned WIN3_PS  = 35000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              req_async,
  input  logic              ack_async,
  output logic              req_clean,
  output logic              ack_clean,
  output logic              req_rise,
  output logic              req_fall,
  output logic              ack_rise,
  output logic              ack_fall
);
  import hs_deglitch_pkg::*;

  localparam int unsigned N1    = win_cycles(WIN1_PS, CLK_PS);
  localparam int unsigned N2    = win_cycles(WIN2_PS, CLK_PS);
  localparam int unsigned N3    = win_cycles(WIN3_PS, CLK_PS);
  localparam int unsigned CNT_W = (N3 < 2) ? 1 : $clog2(N3 + 1);

  logic [1:0]       win_code;
  logic [CNT_W-1:0] limit;
  logic [NUM_LINES-1:0] raw, synced, clean, rise, fall;

  hs_cfg_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(ADDR_W'('hD)), .RESET_VAL(8'h40)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .win_code(win_code)
  );

  always_comb begin
    case (win_code_e'(win_code))
      WIN_BYPASS: limit = '0;
      WIN_SHORT:  limit = CNT_W'(N1);
      WIN_MID:    limit = CNT_W'(N2);
      default:    limit = CNT_W'(N3);
    endcase
  end

  assign raw[LINE_REQ] = req_async;
  assign raw[LINE_ACK] = ack_async;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    hs_sync2 u_sync (.clk(clk), .rst(rst), .d_async(raw[i]), .d_sync(synced[i]));
    hs_width_qual #(.CNT_W(CNT_W)) u_qual (
      .clk(clk), .rst(rst), .din(synced[i]), .limit(limit),
      .q(clean[i]), .rise(rise[i]), .fall(fall[i])
    );
  end

  assign req_clean = clean[LINE_REQ];
  assign ack_clean = clean[LINE_ACK];
  assign req_rise  = rise[LINE_REQ];
  assign req_fall  = fall[LINE_REQ];
  assign ack_rise  = rise[LINE_ACK];
  assign ack_fall  = fall[LINE_ACK];
endmodule

// File: rtl/hs_deglitch_chk.sv
module hs_deglitch_chk (
  input logic clk,
  input logic rst,
  input logic req_async,
  input logic ack_async,
  input logic req_clean,
  input logic ack_clean,
  input logic req_rise,
  input logic req_fall,
  input logic ack_rise,
  input logic ack_fall
);
  p_req_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(req_rise && req_fall));
  p_ack_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(ack_rise && ack_fall));
  p_req_rise_level_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(req_clean) |-> req_rise);
  p_req_fall_level_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(req_clean) |-> req_fall);
  p_ack_rise_level_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_clean) |-> ack_rise);
  p_ack_fall_level_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_clean) |-> ack_fall);
  // R5: a new clean level always equals the raw level three edges back
  p_req_src_r5: assert property (@(posedge clk) disable iff (rst)
    $changed(req_clean) |-> req_clean == $past(req_async, 3));
  p_ack_src_r5: assert property (@(posedge clk) disable iff (rst)
    $changed(ack_clean) |-> ack_clean == $past(ack_async, 3));
endmodule

bind hs_deglitch_top hs_deglitch_chk u_chk (
  .clk(clk), .rst(rst), .req_async(req_async), .ack_async(ack_async),
  .req_clean(req_clean), .ack_clean(ack_clean),
  .req_rise(req_rise), .req_fall(req_fall),
  .ack_rise(ack_rise), .ack_fall(ack_fall)
);

// File: tb/hs_deglitch_top_tb_top.sv
module hs_deglitch_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_addr = 4'h0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       req_async = 1'b0, ack_async = 1'b0;
  logic       req_clean, ack_clean, req_rise, req_fall, ack_rise, ack_fall;

  int checks = 0, failures = 0;
  int n_rr = 0, n_rf = 0, n_ar = 0, n_af = 0;
  bit done = 0;

  always #2ns clk = ~clk;

  hs_deglitch_top #(.ADDR_W(4), .CLK_PS(4000)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_async(req_async), .ack_async(ack_async),
    .req_clean(req_clean), .ack_clean(ack_clean),
    .req_rise(req_rise), .req_fall(req_fall),
    .ack_rise(ack_rise), .ack_fall(ack_fall)
  );

  always @(negedge clk) if (!rst) begin
    n_rr += int'(req_rise); n_rf += int'(req_fall);
    n_ar += int'(ack_rise); n_af += int'(ack_fall);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); cfg_addr = a;
    @(negedge clk); d = cfg_rdata;
  endtask

  // Drive a high pulse on one line for 'w' sampling edges; report strobe deltas.
  task automatic pulse(input bit on_ack, input int w, output int dr, output int df);
    int r0 = on_ack ? n_ar : n_rr;
    int f0 = on_ack ? n_af : n_rf;
    @(negedge clk);
    if (on_ack) ack_async = 1'b1; else req_async = 1'b1;
    repeat (w) @(negedge clk);
    if (on_ack) ack_async = 1'b0; else req_async = 1'b0;
    repeat (30) @(negedge clk);
    dr = (on_ack ? n_ar : n_rr) - r0;
    df = (on_ack ? n_af : n_rf) - f0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 req_clean", req_clean, 0);
    chk("R1 ack_clean", ack_clean, 0);
    chk("R1 strobes", {req_rise, req_fall, ack_rise, ack_fall}, 0);
    rd(4'hD, d);
    chk("R1 ctrl reset", d, 8'h40);
  endtask

  task automatic t_regmap;
    logic [7:0] d;
    wr(4'hC, 8'hFF);
    rd(4'hD, d);  chk("R2 foreign write ignored", d, 8'h40);
    rd(4'hC, d);  chk("R2 other addr reads 0", d, 0);
    wr(4'hD, 8'hA5);
    rd(4'hD, d);  chk("R3 readback", d, 8'hA5);
    wr(4'hD, 8'h40);
  endtask

  task automatic t_latency(input logic [7:0] ctrl, input int n);
    int eff = (n < 1) ? 1 : n;
    wr(4'hD, ctrl);
    @(negedge clk); req_async = 1'b1;
    for (int k = 1; k <= 2 + eff; k++) begin
      @(negedge clk);
      if (k == 1 + eff) chk("R5 rise not early", req_clean, 0);
      if (k == 2 + eff) begin
        chk("R5 rise latency", req_clean, 1);
        chk("R7 rise strobe", req_rise, 1);
      end
    end
    @(negedge clk); chk("R7 rise one cycle", req_rise, 0);
    req_async = 1'b0;
    for (int k = 1; k <= 2 + eff; k++) begin
      @(negedge clk);
      if (k == 1 + eff) chk("R5 fall not early", req_clean, 1);
      if (k == 2 + eff) begin
        chk("R5 fall latency", req_clean, 0);
        chk("R7 fall strobe", req_fall, 1);
      end
    end
    @(negedge clk); chk("R7 fall one cycle", req_fall, 0);
  endtask

  task automatic t_window(input logic [7:0] ctrl, input int n, input string tag);
    int dr, df;
    wr(4'hD, ctrl);
    if (n > 1) begin
      pulse(0, n - 1, dr, df);
      chk({tag, " short rejected rise"}, dr, 0);
      chk({tag, " short rejected fall"}, df, 0);
    end
    pulse(0, n < 1 ? 1 : n, dr, df);
    chk({tag, " exact passes rise"}, dr, 1);
    chk({tag, " exact passes fall"}, df, 1);
  endtask

  task automatic t_reversal;
    int r0 = n_rr;
    wr(4'hD, 8'h40);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); req_async = 1'b1;
      repeat (2) @(negedge clk);
      req_async = 1'b0;
    end
    repeat (30) @(negedge clk);
    chk("R6 reversal restarts count", n_rr - r0, 0);
    chk("R6 clean stays low", req_clean, 0);
  endtask

  task automatic t_low_bits;
    int dr, df;
    wr(4'hD, 8'h7F);
    pulse(0, 2, dr, df); chk("R3 low bits keep 3-cycle window (reject)", dr, 0);
    pulse(0, 3, dr, df); chk("R3 low bits keep 3-cycle window (pass)", dr, 1);
    wr(4'hD, 8'h40);
  endtask

  task automatic t_indep;
    int dr, df, a0, af0;
    wr(4'hD, 8'h40);
    @(negedge clk); ack_async = 1'b1;
    repeat (10) @(negedge clk);
    chk("R8 ack high", ack_clean, 1);
    chk("R8 req untouched by ack", req_clean, 0);
    a0 = n_ar; af0 = n_af;
    pulse(0, 4, dr, df);
    chk("R8 req pulse passes", dr, 1);
    chk("R8 ack no extra strobe", (n_ar - a0) + (n_af - af0), 0);
    chk("R8 ack still high", ack_clean, 1);
    ack_async = 1'b0;
    repeat (10) @(negedge clk);
    pulse(1, 2, dr, df);
    chk("R8 ack short rejected", dr, 0);
  endtask

  initial begin
    #(200000 * 4ns);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_latency(8'h40, 3);
    t_latency(8'h00, 0);
    t_window(8'h40, 3, "R4 code01");
    t_window(8'h80, 6, "R4 code10");
    t_window(8'hC0, 9, "R4 code11");
    t_window(8'h00, 0, "R9 bypass");
    t_window(8'h40, 3, "R6 default");
    t_reversal();
    t_low_bits();
    t_indep();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule